// File: doc/BRIEF.md
# Access-ID Header Timer and Collision Detector

This block times the access-ID part of a phone-line frame header and watches the line while that header goes out. A programmable prescaler turns the system clock into a tick. After a start request the block waits a first spacing, then runs six fixed-length symbols of 130 ticks each, with a programmable spacing between symbols. It closes with a silence interval of fixed length. In each symbol a single pulse sits at one of four tick positions. The position carries two bits of a 12-bit station ID.

In transmit mode the block emits a one-cycle strobe at the pulse position of each symbol. It also checks every pulse it senses on the line. A pulse outside every acceptance window, including the guard ticks at the end of a symbol, counts as a collision. So does a pulse that decodes to a different position from the one being sent, a second pulse in one symbol, a symbol with no pulse, and any pulse in a spacing or in the silence. A collision gives a one-cycle strobe and aborts the header at once. In receive mode the block sends nothing. It decodes the position of each symbol into an ID and flags any symbol that breaks the rules as a receive error.

Top module: `aid_hdr_timer`

## Requirements
- R1: After reset the block is idle: busy_o, tx_pulse_o, coll_o, done_o and rx_err_o are 0 and rx_id_o is 0.
- R2: One tick lasts TICK_DIV clock cycles. Tick 0 of the first symbol begins max(aid_isbi_i,1) ticks after the clock edge that samples start_i.
- R3: Each symbol spans ticks 0 to 129. Between consecutive symbols there are isbi_i idle ticks, and none when isbi_i is 0. The sixth symbol is followed by SIL_TICKS silence ticks. done_o is then high for one cycle, together with the end of busy_o.
- R4: Symbol s (0 to 5) carries code tx_id_i[2s+1:2s]. Code c places the pulse at tick 66+20c. In transmit mode tx_pulse_o is high for the first cycle of that tick only.
- R5: A sensed pulse within ±2 ticks of position 66+20c decodes as code c. When done_o is high, rx_id_o holds the decoded codes at the same bit positions as in R4, and a symbol with no decode reads as 0.
- R6: In transmit mode a pulse outside every window of a symbol is a collision. This includes the guard ticks 129 and those after a window's end.
- R7: In transmit mode a pulse during an inter-symbol spacing or during the silence interval is a collision.
- R8: In transmit mode, each of the following is a collision: a decoded code that differs from the code being sent, a second pulse within one symbol, or a symbol that ends with no decoded pulse. A collision drives coll_o high for exactly one cycle, the cycle after the sampling edge. In that same cycle busy_o is 0, and no further tx_pulse_o or done_o follows.
- R9: tx_mode_i, tx_id_i, isbi_i and aid_isbi_i are sampled only by an accepted start. Changes to them, and start_i pulses, while busy_o is 1 have no effect.
- R10: In receive mode tx_pulse_o and coll_o stay 0. Any pulse that R6 to R8 would treat as a collision, other than a code mismatch, sets rx_err_o, which is reported with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a header; taken only when idle |
| tx_mode_i | input | 1 | 1: transmit and check, 0: receive and decode |
| tx_id_i | input | 12 | ID to send, two bits per symbol |
| isbi_i | input | GAP_W | Spacing between symbols, in ticks |
| aid_isbi_i | input | GAP_W | Spacing before the first symbol, in ticks |
| rx_pulse_i | input | 1 | Pulse sensed on the line, one cycle |
| busy_o | output | 1 | Header sequence in progress |
| tx_pulse_o | output | 1 | Transmit pulse strobe |
| coll_o | output | 1 | Collision strobe; header aborted |
| done_o | output | 1 | Header completed strobe |
| rx_id_o | output | 12 | Decoded ID |
| rx_err_o | output | 1 | Receive-mode rule violation seen |

## Verification
The checker watches, on every cycle, that the collision and done strobes last one cycle, never coincide and always leave the block idle. It also checks that transmit strobes are single-cycle and occur only while busy, and that busy rises only after an accepted start. Only the bench scenarios can show the exact tick at which each pulse and strobe lands for different spacings and codes. The same holds for the ±2-tick window edges and the guard ticks, the decoded ID and receive error, and the fact that spacings changed mid-header are ignored.

// File: rtl/aid_hdr_pkg.sv
package aid_hdr_pkg;
  localparam int SYM_TICKS = 130;
  localparam int N_SYM     = 6;
  localparam int N_POS     = 4;
  localparam int POS_BASE  = 66;
  localparam int POS_STEP  = 20;
  localparam int WIN       = 2;
  localparam int CODE_W    = 2;
  localparam int ID_W      = N_SYM * CODE_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SYM, ST_GAP, ST_SIL
  } hdr_st_e;

  function automatic int pos_tick(int k);
    return POS_BASE + k * POS_STEP;
  endfunction
endpackage

// File: rtl/aid_tick_div.sv
module aid_tick_div #(
  parameter int DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o,
  output logic first_o
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o  = run_i && (cnt_q == LAST);
  assign first_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/aid_pos_decode.sv
module aid_pos_decode
  import aid_hdr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0]  tick_i,
  output logic              hit_o,
  output logic [CODE_W-1:0] code_o
);
  logic [N_POS-1:0] in_win;

  for (genvar k = 0; k < N_POS; k++) begin : g_win
    localparam logic [CNT_W-1:0] LO = CNT_W'(pos_tick(k) - WIN);
    localparam logic [CNT_W-1:0] HI = CNT_W'(pos_tick(k) + WIN);
    assign in_win[k] = (tick_i >= LO) && (tick_i <= HI);
  end

  always_comb begin
    code_o = '0;
    for (int k = 0; k < N_POS; k++)
      if (in_win[k]) code_o = CODE_W'(k);
  end

  assign hit_o = |in_win;
endmodule

// File: rtl/aid_hdr_timer.sv
module aid_hdr_timer
  import aid_hdr_pkg::*;
#(
  parameter int TICK_DIV  = 2,
  parameter int GAP_W     = 8,
  parameter int SIL_TICKS = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tx_mode_i,
  input  logic [ID_W-1:0]  tx_id_i,
  input  logic [GAP_W-1:0] isbi_i,
  input  logic [GAP_W-1:0] aid_isbi_i,
  input  logic             rx_pulse_i,
  output logic             busy_o,
  output logic             tx_pulse_o,
  output logic             coll_o,
  output logic             done_o,
  output logic [ID_W-1:0]  rx_id_o,
  output logic             rx_err_o
);
  localparam int SIL_W = $clog2(SIL_TICKS + 1);
  localparam int W0    = (GAP_W > 8) ? GAP_W : 8;
  localparam int CNT_W = (SIL_W > W0) ? SIL_W : W0;
  localparam int SYM_W = $clog2(N_SYM);
  localparam logic [CNT_W-1:0] SYM_LAST = CNT_W'(SYM_TICKS - 1);
  localparam logic [CNT_W-1:0] SIL_LAST = CNT_W'(SIL_TICKS - 1);
  localparam logic [SYM_W-1:0] SYM_MAX  = SYM_W'(N_SYM - 1);

  hdr_st_e          state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SYM_W-1:0] sym_q;
  logic             mode_q, got_q, err_q, coll_q, done_q;
  logic [ID_W-1:0]  id_q, rxid_q, rxid_d;
  logic [GAP_W-1:0] gap_q, aid_q;

  logic              tick, first;
  logic              dec_hit;
  logic [CODE_W-1:0] dec_code, sent_code;
  logic [CNT_W-1:0]  tx_pos;
  logic [CNT_W:0]    cnt_inc;
  logic              in_sym, sym_end, accept, fault, mismatch, miss;
  logic              coll_cond, rx_fault;

  aid_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (state_q != ST_IDLE),
    .tick_o  (tick),
    .first_o (first)
  );

  aid_pos_decode #(.CNT_W(CNT_W)) u_dec (
    .tick_i (cnt_q),
    .hit_o  (dec_hit),
    .code_o (dec_code)
  );

  always_comb begin
    sent_code = '0;
    rxid_d    = rxid_q;
    for (int s = 0; s < N_SYM; s++) begin
      if (sym_q == SYM_W'(s)) begin
        sent_code = id_q[s*CODE_W +: CODE_W];
        rxid_d[s*CODE_W +: CODE_W] = dec_code;
      end
    end
  end

  always_comb begin
    tx_pos   = CNT_W'(POS_BASE) + CNT_W'(POS_STEP) * CNT_W'(sent_code);
    cnt_inc  = {1'b0, cnt_q} + 1'b1;
    in_sym   = (state_q == ST_SYM);
    sym_end  = in_sym && tick && (cnt_q == SYM_LAST);
    accept   = rx_pulse_i && in_sym && dec_hit && !got_q;
    fault    = rx_pulse_i && ((in_sym && (!dec_hit || got_q)) ||
                              (state_q == ST_GAP) || (state_q == ST_SIL));
    mismatch = accept && (dec_code != sent_code);
    miss     = sym_end && !got_q;
    coll_cond = mode_q && (fault || mismatch || miss);
    rx_fault  = !mode_q && (fault || miss);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sym_q   <= '0;
      mode_q  <= 1'b0;
      id_q    <= '0;
      gap_q   <= '0;
      aid_q   <= '0;
      got_q   <= 1'b0;
      rxid_q  <= '0;
      err_q   <= 1'b0;
      coll_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      coll_q <= coll_cond;
      done_q <= (state_q == ST_SIL) && tick && (cnt_q == SIL_LAST) && !coll_cond;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          state_q <= ST_PRE;
          cnt_q   <= '0;
          sym_q   <= '0;
          mode_q  <= tx_mode_i;
          id_q    <= tx_id_i;
          gap_q   <= isbi_i;
          aid_q   <= aid_isbi_i;
          got_q   <= 1'b0;
          rxid_q  <= '0;
          err_q   <= 1'b0;
        end
      end else if (coll_cond) begin
        state_q <= ST_IDLE;
      end else begin
        if (rx_fault) err_q <= 1'b1;
        if (accept) begin
          got_q  <= 1'b1;
          rxid_q <= rxid_d;
        end
        if (tick) begin
          unique case (state_q)
            ST_PRE: begin
              if (cnt_inc >= (CNT_W+1)'(aid_q)) begin
                state_q <= ST_SYM;
                cnt_q   <= '0;
              end else cnt_q <= cnt_inc[CNT_W-1:0];
            end
            ST_SYM: begin
              if (cnt_q == SYM_LAST) begin
                cnt_q <= '0;
                got_q <= 1'b0;
                if (sym_q == SYM_MAX)  state_q <= ST_SIL;
                else begin
                  sym_q <= sym_q + 1'b1;
                  if (gap_q != '0)     state_q <= ST_GAP;
                end
              end else cnt_q <= cnt_inc[CNT_W-1:0];
            end
            ST_GAP: begin
              if (cnt_inc >= (CNT_W+1)'(gap_q)) begin
                state_q <= ST_SYM;
                cnt_q   <= '0;
              end else cnt_q <= cnt_inc[CNT_W-1:0];
            end
            ST_SIL: begin
              if (cnt_q == SIL_LAST) state_q <= ST_IDLE;
              else                   cnt_q   <= cnt_inc[CNT_W-1:0];
            end
            default: state_q <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign tx_pulse_o = mode_q && in_sym && first && (cnt_q == tx_pos);
  assign coll_o     = coll_q;
  assign done_o     = done_q;
  assign rx_id_o    = rxid_q;
  assign rx_err_o   = err_q;
endmodule

// File: rtl/aid_hdr_timer_chk.sv
module aid_hdr_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic tx_pulse_o,
  input logic coll_o,
  input logic done_o
);
  assert_coll_not_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_o |-> !done_o);
  assert_coll_aborts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_o |-> !busy_o);
  assert_coll_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_o |=> !coll_o);
  assert_done_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_txp_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pulse_o |=> !tx_pulse_o);
  assert_txp_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pulse_o |-> busy_o);
  assert_start_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

bind aid_hdr_timer aid_hdr_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .tx_pulse_o (tx_pulse_o),
  .coll_o     (coll_o),
  .done_o     (done_o)
);

// File: tb/tb_aid_hdr_timer.sv
module tb_aid_hdr_timer;
  localparam int D   = 2;
  localparam int GW  = 8;
  localparam int SIL = 40;
  localparam int K_TXP = 0, K_COLL = 1, K_DONE = 2;

  typedef struct {
    int         kind;
    int         cyc;
    logic [11:0] id;
    logic       err;
    string      req;
  } ev_t;

  logic clk = 0, rst_n = 0;
  logic start = 0, mode = 0, rxp = 0;
  logic [11:0] txid = '0;
  logic [GW-1:0] isbi = '0, aisbi = '0;
  logic busy, txp, coll, done, rerr;
  logic [11:0] rid;

  int checks = 0, fails = 0;
  int cyc = 0, t0 = 0;
  bit running = 0;
  ev_t exp_q[$];
  bit inj[int];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aid_hdr_timer #(.TICK_DIV(D), .GAP_W(GW), .SIL_TICKS(SIL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_mode_i(mode),
    .tx_id_i(txid), .isbi_i(isbi), .aid_isbi_i(aisbi), .rx_pulse_i(rxp),
    .busy_o(busy), .tx_pulse_o(txp), .coll_o(coll), .done_o(done),
    .rx_id_o(rid), .rx_err_o(rerr)
  );

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int tcyc(int a, int g, int s, int t);
    int ae = (a < 1) ? 1 : a;
    return (ae + s * (130 + g) + t) * D;
  endfunction

  function automatic int pos(logic [11:0] id, int s);
    return 66 + 20 * int'(id[2*s +: 2]);
  endfunction

  function automatic void push(int kind, int c, logic [11:0] id, logic err, string req);
    ev_t e;
    e.kind = kind; e.cyc = c; e.id = id; e.err = err; e.req = req;
    exp_q.push_back(e);
  endfunction

  task automatic handle(int kind);
    ev_t e;
    int k = cyc - t0;
    if (exp_q.size() == 0) begin
      check(0, "R8", "unexpected event kind", kind, -1);
      return;
    end
    e = exp_q.pop_front();
    check(e.kind == kind, e.req, "event kind", kind, e.kind);
    check(e.cyc == k, e.req, "event cycle", k, e.cyc);
    if (kind == K_DONE) begin
      check(rid == e.id, "R5", "rx_id", int'(rid), int'(e.id));
      check(rerr == e.err, "R10", "rx_err", int'(rerr), int'(e.err));
    end
  endtask

  // monitor and injector, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      if (txp)  handle(K_TXP);
      if (coll) handle(K_COLL);
      if (done) handle(K_DONE);
      rxp <= inj.exists(cyc - t0);
    end else rxp <= 1'b0;
  end

  task automatic go(bit m, logic [11:0] id, int a, int g);
    @(negedge clk);
    mode = m; txid = id; aisbi = GW'(a); isbi = GW'(g); start = 1;
    @(posedge clk);
    #1;
    t0 = cyc;
    running = 1;
    start = 0;
  endtask

  task automatic finish_hdr(string req);
    int n = 0;
    while (busy && n < 5000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
    check(!busy, req, "busy after header", int'(busy), 0);
    check(exp_q.size() == 0, req, "pending expected events", exp_q.size(), 0);
    exp_q.delete();
    inj.delete();
    running = 0;
  endtask

  // echo symbols 0..n-1 back as the sensed line and expect their strobes
  task automatic echo(logic [11:0] id, int a, int g, int n, string req);
    for (int s = 0; s < n; s++) begin
      int c = tcyc(a, g, s, pos(id, s));
      push(K_TXP, c, '0, 1'b0, req);
      inj[c] = 1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !txp && !coll && !done && !rerr, "R1", "idle outputs", 0, 0);
    check(rid == 0, "R1", "rx_id reset", int'(rid), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 R4: full transmit header with echo
    echo(12'h1B4, 5, 3, 6, "R4");
    push(K_DONE, tcyc(5, 3, 5, 130 + SIL), 12'h1B4, 1'b0, "R3");
    go(1, 12'h1B4, 5, 3);
    finish_hdr("R3");

    // R2: zero first spacing counts as one tick, no inter-symbol gap
    echo(12'hFFF, 0, 0, 6, "R2");
    push(K_DONE, tcyc(0, 0, 5, 130 + SIL), 12'hFFF, 1'b0, "R2");
    go(1, 12'hFFF, 0, 0);
    finish_hdr("R2");

    // R5: receive mode, window edges
    begin
      int off [6] = '{-2, 2, 0, 1, -1, 0};
      for (int s = 0; s < 6; s++) inj[tcyc(4, 2, s, pos(12'h2C6, s) + off[s])] = 1;
      push(K_DONE, tcyc(4, 2, 5, 130 + SIL), 12'h2C6, 1'b0, "R5");
      go(0, 12'h000, 4, 2);
      finish_hdr("R5");
    end

    // R10: receive mode, missing symbol 3 and guard pulse in symbol 1
    begin
      logic [11:0] sid = 12'h9E7;
      logic [11:0] eid = sid & ~12'h0C0;
      for (int s = 0; s < 6; s++) if (s != 3) inj[tcyc(3, 1, s, pos(sid, s))] = 1;
      inj[tcyc(3, 1, 1, 129)] = 1;
      push(K_DONE, tcyc(3, 1, 5, 130 + SIL), eid, 1'b1, "R10");
      go(0, 12'hFFF, 3, 1);
      finish_hdr("R10");
    end

    // R8: code mismatch in symbol 2 (sends code 3, line shows code 0)
    echo(12'h3F5, 2, 2, 2, "R8");
    begin
      int c = tcyc(2, 2, 2, 66);
      inj[c] = 1;
      push(K_COLL, c + 1, '0, 1'b0, "R8");
    end
    go(1, 12'h3F5, 2, 2);
    finish_hdr("R8");

    // R6: pulse three ticks after the window centre (outside window)
    begin
      int c = tcyc(2, 2, 0, 89);
      push(K_TXP, tcyc(2, 2, 0, 86), '0, 1'b0, "R6");
      inj[c] = 1;
      push(K_COLL, c + 1, '0, 1'b0, "R6");
      go(1, 12'h001, 2, 2);
      finish_hdr("R6");
    end

    // R6: guard tick 129 after a code-3 pulse echo
    begin
      int c = tcyc(2, 0, 0, 129);
      push(K_TXP, tcyc(2, 0, 0, 126), '0, 1'b0, "R6");
      inj[tcyc(2, 0, 0, 126)] = 1;
      inj[c] = 1;
      push(K_COLL, c + 1, '0, 1'b0, "R6");
      go(1, 12'h003, 2, 0);
      finish_hdr("R6");
    end

    // R8: missing pulse in symbol 1
    echo(12'h0A6, 3, 4, 1, "R8");
    push(K_TXP, tcyc(3, 4, 1, pos(12'h0A6, 1)), '0, 1'b0, "R8");
    push(K_COLL, tcyc(3, 4, 1, 130), '0, 1'b0, "R8");
    go(1, 12'h0A6, 3, 4);
    finish_hdr("R8");

    // R7: pulse inside the silence interval
    echo(12'h555, 2, 1, 6, "R7");
    begin
      int c = tcyc(2, 1, 5, 140);
      inj[c] = 1;
      push(K_COLL, c + 1, '0, 1'b0, "R7");
    end
    go(1, 12'h555, 2, 1);
    finish_hdr("R7");

    // R7: pulse inside an inter-symbol spacing
    echo(12'h002, 2, 5, 1, "R7");
    begin
      int c = tcyc(2, 5, 0, 132);
      inj[c] = 1;
      push(K_COLL, c + 1, '0, 1'b0, "R7");
    end
    go(1, 12'h002, 2, 5);
    finish_hdr("R7");

    // R8: second pulse within the same window
    begin
      int c = tcyc(1, 1, 0, 67);
      echo(12'h000, 1, 1, 1, "R8");
      inj[c] = 1;
      push(K_COLL, c + 1, '0, 1'b0, "R8");
      go(1, 12'h000, 1, 1);
      finish_hdr("R8");
    end

    // R9: mid-header changes and a second start are ignored
    echo(12'h6C9, 4, 2, 6, "R9");
    push(K_DONE, tcyc(4, 2, 5, 130 + SIL), 12'h6C9, 1'b0, "R9");
    go(1, 12'h6C9, 4, 2);
    repeat (300) @(negedge clk);
    isbi = 8'd50; aisbi = 8'd90; mode = 0; txid = 12'h000; start = 1;
    @(negedge clk);
    start = 0;
    finish_hdr("R9");
    check(!busy && !txp, "R9", "no restart after header", int'(busy), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule